// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a processor access to a physical address may proceed. It holds a set of regions. Each region has an address, a matching mode, independent read, write and execute permission bits, and a lock bit. Every access request carries an address, an access type and the privilege mode of the requester. The block finds the lowest-numbered region that covers the address and applies that region's permissions. It then combines that result with a separate physical-attribute verdict that arrives on an input. The outputs are a grant or an access fault. The block produces no cache attributes.

The regions are configured through a register write port. That port honours a write only when the current privilege mode is machine mode. Bounds are compared at a 1 KB grain, so the low ten address bits never affect a decision. The decision is combinational: the grant or fault for an access appears in the same cycle as the request. A configuration write takes effect at the next clock edge.

Top module: `pmp_checker`

## Requirements
- R1: The region count is the parameter NUM_REGIONS (1 to 16, default 16). A region's configuration byte, written with cfg_sel_i=0, holds read permission in bit 0, write permission in bit 1, execute permission in bit 2, the match mode in bits 4:3 and the lock in bit 7. Bits 6:5 are ignored. The permission bit for the access type decides a matched access: acc_type_i 2'b00 is read, 2'b01 is write and 2'b10 is execute.
- R2: A configuration write takes effect at the rising clock edge on which cfg_we_i is high. An access presented in the same cycle is decided with the configuration from before that write.
- R3: A configuration write is applied only when cur_mode_i is 2'b11 (machine). With cur_mode_i 2'b00 (user) or 2'b01 (supervisor), the write changes no region.
- R4: An address write (cfg_sel_i=1) stores cfg_wdata_i[31:10]. Region bounds are compared on acc_addr_i[31:10] only, so address bits 9:0 affect neither the stored bound nor the match.
- R5: grant_o is high only when acc_valid_i is high, the protection check passes and pma_allow_i is high. fault_o equals acc_valid_i and not grant_o.
- R6: In top-of-range mode (bits 4:3 = 2'b01), region i matches when A(i-1) <= addr[31:10] < A(i). Here A(k) is region k's stored address, and the lower bound of region 0 is 0.
- R7: In power-of-two mode (bits 4:3 = 2'b10 or 2'b11), a stored address with k trailing one bits covers a naturally aligned block of 2^(k+1) KB. The block is found by ignoring those k bits and the zero bit above them. Mode 2'b00 disables the region.
- R8: When several regions match, the region with the lowest index alone decides the access.
- R9: An access that matches no region is allowed in machine mode (acc_mode_i 2'b11). In user or supervisor mode it is allowed only when every region is disabled; otherwise it faults.
- R10: A region whose lock bit is set ignores all later writes to its configuration byte and its address until reset. A matched machine-mode access obeys the permissions of a locked region. A matched machine-mode access to an unlocked region is allowed.
- R11: With acc_valid_i low, both grant_o and fault_o are low.
- R12: After reset, every region is disabled, unlocked and holds a zero address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0: configuration byte, 1: region address |
| cfg_idx_i | input | 4 | Region index of the write |
| cfg_wdata_i | input | 32 | Write data |
| cur_mode_i | input | 2 | Privilege mode of the writer |
| acc_valid_i | input | 1 | Access request present |
| acc_addr_i | input | 32 | Physical address of the access |
| acc_type_i | input | 2 | 00 read, 01 write, 10 execute |
| acc_mode_i | input | 2 | Privilege mode of the access |
| pma_allow_i | input | 1 | External physical-attribute check passed |
| grant_o | output | 1 | Access granted |
| fault_o | output | 1 | Access fault |

## Verification
A configuration write and an access decision can fall in the same cycle. The bench provokes this by raising cfg_we_i together with acc_valid_i on one clock. It first enables a region that covers the access address, and it expects the fault that the old, empty configuration gives. On the next cycle, the same user-mode access must be granted under the new configuration. In a second collision, a locked region receives a rewrite while a machine-mode access probes it. The bench judges both that the locked permissions still apply and that the rewrite leaves no trace on later accesses.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

  typedef enum logic [1:0] {
    PRIV_U = 2'b00,
    PRIV_S = 2'b01,
    PRIV_M = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    ACC_R = 2'b00,
    ACC_W = 2'b01,
    ACC_X = 2'b10
  } acc_e;

  typedef enum logic [1:0] {
    AM_OFF   = 2'b00,
    AM_TOR   = 2'b01,
    AM_NAPOT = 2'b10
  } amode_e;

  // Stored region config; byte positions are mapped in pmp_cfg_regs
  typedef struct packed {
    logic       lock;
    logic [1:0] amode;
    logic       x;
    logic       w;
    logic       r;
  } pmp_cfg_t;

  localparam int unsigned CFG_LOCK_BIT = 7;
  localparam int unsigned CFG_AM_HI    = 4;
  localparam int unsigned CFG_AM_LO    = 3;

endpackage

// File: rtl/pmp_cfg_regs.sv
module pmp_cfg_regs
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned GRAIN_LSB   = 10,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned AGW   = ADDR_W - GRAIN_LSB
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             we_i,
  input  logic                             sel_i,
  input  logic [IDX_W-1:0]                 idx_i,
  input  logic [ADDR_W-1:0]                wdata_i,
  input  logic [1:0]                       mode_i,
  output pmp_cfg_t [NUM_REGIONS-1:0]       cfg_o,
  output logic [NUM_REGIONS-1:0][AGW-1:0]  addr_o
);

  logic     wr_ok;
  pmp_cfg_t cfg_new;
  logic     unused_wdata;

  assign wr_ok   = we_i && (mode_i == PRIV_M);
  assign cfg_new = '{lock:  wdata_i[CFG_LOCK_BIT],
                     amode: wdata_i[CFG_AM_HI:CFG_AM_LO],
                     x:     wdata_i[2],
                     w:     wdata_i[1],
                     r:     wdata_i[0]};
  assign unused_wdata = ^{wdata_i[6:5], wdata_i[GRAIN_LSB-1:8]};

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_reg
    logic hit_wr;
    assign hit_wr = wr_ok && (idx_i == IDX_W'(g)) && !cfg_o[g].lock;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[g]  <= '0;
        addr_o[g] <= '0;
      end else if (hit_wr) begin
        if (sel_i) addr_o[g] <= wdata_i[ADDR_W-1:GRAIN_LSB];
        else       cfg_o[g]  <= cfg_new;
      end
    end
  end

endmodule

// File: rtl/pmp_region_match.sv
module pmp_region_match
  import pmp_pkg::*;
#(
  parameter int unsigned AGW = 22
) (
  input  logic [1:0]     amode_i,
  input  logic [AGW-1:0] addr_g_i,
  input  logic [AGW-1:0] lo_g_i,
  input  logic [AGW-1:0] hi_g_i,
  output logic           hit_o
);

  logic [AGW-1:0] napot_mask;
  logic           tor_hit;
  logic           napot_hit;

  // trailing ones plus the zero above them
  assign napot_mask = hi_g_i ^ (hi_g_i + AGW'(1));
  assign tor_hit    = (addr_g_i >= lo_g_i) && (addr_g_i < hi_g_i);
  assign napot_hit  = ((addr_g_i ^ hi_g_i) & ~napot_mask) == '0;

  always_comb begin
    unique case (amode_i)
      AM_OFF:  hit_o = 1'b0;
      AM_TOR:  hit_o = tor_hit;
      default: hit_o = napot_hit;
    endcase
  end

endmodule

// File: rtl/pmp_decide.sv
module pmp_decide
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16
) (
  input  logic [NUM_REGIONS-1:0]     hit_i,
  input  pmp_cfg_t [NUM_REGIONS-1:0] cfg_i,
  input  logic [1:0]                 acc_type_i,
  input  logic [1:0]                 acc_mode_i,
  output logic                       pass_o
);

  logic     found;
  logic     any_on;
  logic     perm;
  logic     is_m;
  pmp_cfg_t sel;

  // scan high to low so the lowest hit is the last assignment
  always_comb begin
    found  = 1'b0;
    any_on = 1'b0;
    sel    = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
      if (cfg_i[i].amode != AM_OFF) any_on = 1'b1;
      if (hit_i[i]) begin
        found = 1'b1;
        sel   = cfg_i[i];
      end
    end
  end

  always_comb begin
    unique case (acc_type_i)
      ACC_R:   perm = sel.r;
      ACC_W:   perm = sel.w;
      ACC_X:   perm = sel.x;
      default: perm = 1'b0;
    endcase
  end

  assign is_m = (acc_mode_i == PRIV_M);

  always_comb begin
    if (found) pass_o = (is_m && !sel.lock) ? 1'b1 : perm;
    else       pass_o = is_m || !any_on;
  end

endmodule

// File: rtl/pmp_checker.sv
module pmp_checker
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned GRAIN_LSB   = 10,
  localparam int unsigned IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int unsigned AGW   = ADDR_W - GRAIN_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_sel_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_wdata_i,
  input  logic [1:0]        cur_mode_i,
  input  logic              acc_valid_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic [1:0]        acc_type_i,
  input  logic [1:0]        acc_mode_i,
  input  logic              pma_allow_i,
  output logic              grant_o,
  output logic              fault_o
);

  pmp_cfg_t [NUM_REGIONS-1:0]       cfg_q;
  logic [NUM_REGIONS-1:0][AGW-1:0]  addr_q;
  logic [NUM_REGIONS-1:0]           hit;
  logic [AGW-1:0]                   addr_g;
  logic                             pmp_pass;
  logic                             unused_addr;

  assign addr_g      = acc_addr_i[ADDR_W-1:GRAIN_LSB];
  assign unused_addr = ^acc_addr_i[GRAIN_LSB-1:0];

  pmp_cfg_regs #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .GRAIN_LSB   (GRAIN_LSB)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .sel_i   (cfg_sel_i),
    .idx_i   (cfg_idx_i),
    .wdata_i (cfg_wdata_i),
    .mode_i  (cur_mode_i),
    .cfg_o   (cfg_q),
    .addr_o  (addr_q)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
    logic [AGW-1:0] lo;
    if (g == 0) begin : g_first
      assign lo = '0;
    end else begin : g_next
      assign lo = addr_q[g-1];
    end

    pmp_region_match #(.AGW(AGW)) u_match (
      .amode_i  (cfg_q[g].amode),
      .addr_g_i (addr_g),
      .lo_g_i   (lo),
      .hi_g_i   (addr_q[g]),
      .hit_o    (hit[g])
    );
  end

  pmp_decide #(.NUM_REGIONS(NUM_REGIONS)) u_decide (
    .hit_i      (hit),
    .cfg_i      (cfg_q),
    .acc_type_i (acc_type_i),
    .acc_mode_i (acc_mode_i),
    .pass_o     (pmp_pass)
  );

  assign grant_o = acc_valid_i && pmp_pass && pma_allow_i;
  assign fault_o = acc_valid_i && !grant_o;

endmodule

// File: rtl/pmp_checker_chk.sv
module pmp_checker_chk
  import pmp_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 16,
  parameter int unsigned AGW         = 22
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            cfg_we_i,
  input logic [1:0]                      cur_mode_i,
  input logic                            acc_valid_i,
  input logic                            pma_allow_i,
  input logic                            grant_o,
  input logic                            fault_o,
  input pmp_cfg_t [NUM_REGIONS-1:0]      cfg_q,
  input logic [NUM_REGIONS-1:0][AGW-1:0] addr_q
);

  // R5
  grant_needs_pma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> pma_allow_i);

  // R5
  pma_deny_faults_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && !pma_allow_i) |-> (fault_o && !grant_o));

  // R11
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |-> (!grant_o && !fault_o));

  // R5
  one_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |-> $onehot({grant_o, fault_o}));

  // R3
  low_mode_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cur_mode_i != PRIV_M) |=> ($stable(cfg_q) && $stable(addr_q)));

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_we_i |=> ($stable(cfg_q) && $stable(addr_q)));

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_lock
    // R10
    lock_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_q[g].lock |=> (cfg_q[g].lock && $stable(cfg_q[g]) && $stable(addr_q[g])));
  end

endmodule

bind pmp_checker pmp_checker_chk #(
  .NUM_REGIONS (NUM_REGIONS),
  .AGW         (AGW)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cur_mode_i  (cur_mode_i),
  .acc_valid_i (acc_valid_i),
  .pma_allow_i (pma_allow_i),
  .grant_o     (grant_o),
  .fault_o     (fault_o),
  .cfg_q       (cfg_q),
  .addr_q      (addr_q)
);

// File: tb/sim_pmp_checker.sv
`timescale 1ns/1ps
module sim_pmp_checker;

  localparam logic [1:0] M = 2'b11, S = 2'b01, U = 2'b00;
  localparam logic [1:0] RD = 2'b00, WR = 2'b01, EX = 2'b10;

  typedef struct {
    logic  g;
    logic  f;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  cur_mode = U;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_type = RD;
  logic [1:0]  acc_mode = U;
  logic        pma_allow = 1'b1;
  logic        grant, fault;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  pmp_checker u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_sel_i   (cfg_sel),
    .cfg_idx_i   (cfg_idx),
    .cfg_wdata_i (cfg_wdata),
    .cur_mode_i  (cur_mode),
    .acc_valid_i (acc_valid),
    .acc_addr_i  (acc_addr),
    .acc_type_i  (acc_type),
    .acc_mode_i  (acc_mode),
    .pma_allow_i (pma_allow),
    .grant_o     (grant),
    .fault_o     (fault)
  );

  task automatic drive_acc(input logic [31:0] a, input logic [1:0] t, input logic [1:0] m,
                           input logic pma, input logic eg, input string req);
    @(negedge clk);
    cfg_we    = 1'b0;
    acc_valid = 1'b1;
    acc_addr  = a;
    acc_type  = t;
    acc_mode  = m;
    pma_allow = pma;
    q.push_back('{g: eg, f: !eg, req: req});
  endtask

  task automatic drive_idle(input string req);
    @(negedge clk);
    cfg_we    = 1'b0;
    acc_valid = 1'b0;
    q.push_back('{g: 1'b0, f: 1'b0, req: req});
  endtask

  task automatic drive_wr(input logic sel, input logic [3:0] idx, input logic [31:0] d,
                          input logic [1:0] m);
    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_idx   = idx;
    cfg_wdata = d;
    cur_mode  = m;
  endtask

  // write and access in the same cycle
  task automatic drive_both(input logic sel, input logic [3:0] idx, input logic [31:0] d,
                            input logic [1:0] wm, input logic [31:0] a, input logic [1:0] t,
                            input logic [1:0] m, input logic eg, input string req);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_sel   = sel;
    cfg_idx   = idx;
    cfg_wdata = d;
    cur_mode  = wm;
    acc_valid = 1'b1;
    acc_addr  = a;
    acc_type  = t;
    acc_mode  = m;
    pma_allow = 1'b1;
    q.push_back('{g: eg, f: !eg, req: req});
  endtask

  // monitor: sample mid-cycle after the driver's negedge update
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (grant !== e.g || fault !== e.f) begin
          errors++;
          $display("FAIL %s: grant/fault actual %b/%b expected %b/%b", e.req, grant, fault,
                   e.g, e.f);
        end
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;

    // R12 / R11 reset state
    drive_idle("R11");
    drive_acc(32'h0000_1000, RD, U, 1'b1, 1'b1, "R12");
    drive_acc(32'h0000_1000, WR, S, 1'b1, 1'b1, "R9");

    // region0 TOR [0,0x4000) read only
    drive_wr(1'b1, 4'd0, 32'h0000_4000, M);
    drive_wr(1'b0, 4'd0, 32'h0000_0009, M);
    drive_acc(32'h0000_3FFF, RD, U, 1'b1, 1'b1, "R6");
    drive_acc(32'h0000_3FFF, WR, U, 1'b1, 1'b0, "R1");
    drive_acc(32'h0000_4000, RD, U, 1'b1, 1'b0, "R9");
    drive_acc(32'h0000_8000, RD, M, 1'b1, 1'b1, "R9");
    drive_acc(32'h0000_0100, WR, M, 1'b1, 1'b1, "R10");
    drive_acc(32'h0000_0100, RD, U, 1'b0, 1'b0, "R5");
    drive_idle("R11");

    // region1 TOR [0x4000,0x8000) RWX; region2 NAPOT 32 KB at 0 execute only
    drive_wr(1'b1, 4'd1, 32'h0000_8000, M);
    drive_wr(1'b0, 4'd1, 32'h0000_000F, M);
    drive_wr(1'b1, 4'd2, 32'h0000_3C00, M);
    drive_wr(1'b0, 4'd2, 32'h0000_0014, M);
    drive_acc(32'h0000_5000, WR, U, 1'b1, 1'b1, "R8");
    drive_acc(32'h0000_3000, EX, U, 1'b1, 1'b0, "R8");
    drive_acc(32'h0000_7000, EX, S, 1'b1, 1'b1, "R6");

    // region3 NAPOT 2 KB at 0xC000 read only
    drive_wr(1'b1, 4'd3, 32'h0000_C000, M);
    drive_wr(1'b0, 4'd3, 32'h0000_0011, M);
    drive_acc(32'h0000_C7FF, RD, U, 1'b1, 1'b1, "R7");
    drive_acc(32'h0000_C800, RD, U, 1'b1, 1'b0, "R7");
    drive_acc(32'h0000_BFFF, RD, U, 1'b1, 1'b0, "R7");

    // lower-mode writes ignored
    drive_wr(1'b1, 4'd4, 32'h0001_0000, S);
    drive_wr(1'b0, 4'd4, 32'h0000_000F, U);
    drive_acc(32'h0000_E000, RD, U, 1'b1, 1'b0, "R3");

    // same-cycle write and access
    drive_wr(1'b1, 4'd4, 32'h0001_0000, M);
    drive_both(1'b0, 4'd4, 32'h0000_000F, M, 32'h0000_E000, RD, U, 1'b0, "R2");
    drive_acc(32'h0000_E000, RD, U, 1'b1, 1'b1, "R2");

    // region5 TOR [0x10000,0x14000) read only, locked; low wdata bits dropped
    drive_wr(1'b1, 4'd5, 32'h0001_43FF, M);
    drive_wr(1'b0, 4'd5, 32'h0000_0089, M);
    drive_acc(32'h0001_3FFF, RD, U, 1'b1, 1'b1, "R4");
    drive_acc(32'h0001_4000, RD, U, 1'b1, 1'b0, "R4");
    drive_acc(32'h0001_2000, WR, M, 1'b1, 1'b0, "R10");
    drive_acc(32'h0001_2000, RD, M, 1'b1, 1'b1, "R10");
    drive_both(1'b0, 4'd5, 32'h0000_000F, M, 32'h0001_2000, WR, M, 1'b0, "R10");
    drive_acc(32'h0001_2000, WR, U, 1'b1, 1'b0, "R10");
    drive_wr(1'b1, 4'd5, 32'h0002_0000, M);
    drive_acc(32'h0001_5000, RD, U, 1'b1, 1'b0, "R10");
    drive_acc(32'h0001_5000, RD, M, 1'b1, 1'b1, "R9");
    drive_idle("R11");

    @(negedge clk);
    acc_valid = 1'b0;
    cfg_we    = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule